// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Programming Sequencer

This block plays the part of the programming equipment for a byte-wide memory whose cells start at all ones and can only be cleared to zero. A single `start` pulse begins a run. The block first raises the elevated supply and the programming voltage. It then makes a blind pass that gives every address one program pulse of fixed width on the active-low chip enable. A second pass reads each byte back and compares it with the source. On a mismatch it gives the byte another pulse, up to a fixed number of extra pulses. When every byte has verified, it drops both enables and reads the whole array again at normal supply, comparing each byte with the source.

The source image is read through a simple synchronous port: the sequencer presents an address, and the byte is valid one clock later. All timing intervals are counted in clock cycles, derived from a clock frequency in MHz and from parameters in microseconds. These cover pulse width, setup, hold and data-valid delay. The voltage enables are plain digital outputs for an external supply circuit. The data bus is split into an outgoing byte, an incoming byte and a direction flag.

The run ends with a one-cycle `done`, a pass flag and, on failure, the address that failed.

Top module: `otp_prog_seq`

## Requirements
- R1: While reset is held, the block is idle and quiet: `busy`, `done` and `passOk` low, `memCeN` and `memOeN` high, `vppEn`, `vccHiEn` and `memDataOe` low.
- R2: A `start` sampled high while idle raises `busy`, `vppEn` and `vccHiEn` on the next cycle, with `memAddr` at 0.
- R3: The first pass gives exactly one program pulse per address, in ascending order from 0 to the last address. A program pulse means `memCeN` low with `memOeN` high. Every pulse lasts exactly CLK_MHZ*PULSE_US cycles.
- R4: During every program pulse, `vppEn`, `vccHiEn` and `memDataOe` are high, and address and outgoing data do not change. Address, data and `vppEn` have each been steady for at least CLK_MHZ*SETUP_US cycles before the pulse starts. The address does not change within CLK_MHZ*HOLD_US cycles after the pulse ends.
- R5: Every read has `memCeN` and `memOeN` low, with `vppEn` low and the bus released. The incoming byte is judged CLK_MHZ*VALID_US cycles after the read begins.
- R6: The second pass starts at address 0. On a verify mismatch, the same address receives another program pulse and is verified again, up to MAX_RETRY extra pulses. The count of extra pulses restarts at zero for each address.
- R7: If a byte still mismatches after MAX_RETRY extra pulses, the run ends at once with `passOk` low and `failAddr` set to that address. Both enables drop and no further pulse is given.
- R8: After the second pass, the final compare reads addresses from 0 upward with `vppEn` and `vccHiEn` both low. The first mismatch ends the run with `passOk` low and `failAddr` set to that address.
- R9: When the final compare matches at every address, `passOk` goes high. `done` is high for exactly one cycle, in the same cycle that `busy` falls.
- R10: `start` has no effect while `busy` is high. A run disturbed by a stray `start` gives the same pulse count and result as an undisturbed one.
- R11: `memDataOe` is high only around program pulses and never while `memOeN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| passOk | output | 1 | Run result, valid from `done` until next start |
| failAddr | output | ADDR_W | Address at which the run failed |
| srcAddr | output | ADDR_W | Source image read address |
| srcData | input | DATA_W | Source byte, valid one cycle after `srcAddr` |
| memAddr | output | ADDR_W | Memory address |
| memDataOut | output | DATA_W | Byte driven to the memory |
| memDataIn | input | DATA_W | Byte read back from the memory |
| memDataOe | output | 1 | 1 while the sequencer drives the data bus |
| memCeN | output | 1 | Active-low chip enable / program pulse |
| memOeN | output | 1 | Active-low output enable |
| vppEn | output | 1 | Programming-voltage enable |
| vccHiEn | output | 1 | Elevated-supply enable |

## Verification
A wrong phase state shows at the pins within one cycle. It appears as a pulse with the voltage off, a read with the bus still driven, or a read at the wrong supply level. A timer that loaded the wrong value shows when the affected pulse ends, as a width or setup interval that differs from the parameter. A retry counter that clears or saturates wrongly cannot be seen until the run finishes. It then shows up as a total pulse count, a result or a failing address that differs from what the memory model predicts. An address counter fault breaks the ascending order of first-pass pulses at the first affected address.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RAMP,
    ST_PFETCH,
    ST_ARM,
    ST_PULSE,
    ST_HOLD,
    ST_VFETCH,
    ST_VOPEN,
    ST_VREAD,
    ST_FRAMP,
    ST_CFETCH,
    ST_CREAD
  } seq_state_t;

  // control -> datapath strobes
  typedef struct packed {
    logic addrClr;
    logic addrInc;
    logic loadExp;
    logic clrResult;
    logic setPass;
    logic setFail;
    logic finish;
  } seq_strobe_t;

  function automatic int unsigned usToCycles(input int unsigned mhz, input int unsigned us);
    int unsigned n;
    n = mhz * us;
    return (n < 1) ? 1 : n;
  endfunction

endpackage

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_prog_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 250,
  parameter int unsigned PULSE_CYC = 6250,
  parameter int unsigned HOLD_CYC  = 250,
  parameter int unsigned VALID_CYC = 125,
  parameter int unsigned MAX_RETRY = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        lastAddr,
  input  logic        match,
  output seq_strobe_t strb,
  output logic        busy,
  output logic        memCeN,
  output logic        memOeN,
  output logic        vppEn,
  output logic        vccHiEn,
  output logic        memDataOe
);

  localparam int unsigned FETCH_CYC = 2;  // synchronous source port latency + capture
  localparam int unsigned MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int unsigned MAX_B = (HOLD_CYC > VALID_CYC) ? HOLD_CYC : VALID_CYC;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TMAX  = (MAX_C > FETCH_CYC) ? MAX_C : FETCH_CYC;
  localparam int TW = $clog2(TMAX + 1);
  localparam int RW = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

  seq_state_t      stateQ, stateD;
  logic [TW-1:0]   timerQ;
  logic [RW-1:0]   retryQ, retryD;
  logic            inVerifyQ, inVerifyD;
  logic            tDone;

  function automatic logic [TW-1:0] durOf(input seq_state_t s);
    int unsigned d;
    case (s)
      ST_RAMP, ST_ARM, ST_VOPEN, ST_FRAMP: d = SETUP_CYC;
      ST_PULSE:                            d = PULSE_CYC;
      ST_HOLD:                             d = HOLD_CYC;
      ST_VREAD, ST_CREAD:                  d = VALID_CYC;
      ST_PFETCH, ST_VFETCH, ST_CFETCH:     d = FETCH_CYC;
      default:                             d = 1;
    endcase
    return TW'(d - 1);
  endfunction

  assign tDone = (timerQ == '0);

  always_comb begin
    stateD    = stateQ;
    retryD    = retryQ;
    inVerifyD = inVerifyQ;
    strb      = '0;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          stateD         = ST_RAMP;
          strb.addrClr   = 1'b1;
          strb.clrResult = 1'b1;
          inVerifyD      = 1'b0;
          retryD         = '0;
        end
      end
      ST_RAMP:   if (tDone) stateD = ST_PFETCH;
      ST_PFETCH: begin
        if (tDone) begin
          strb.loadExp = 1'b1;
          stateD       = ST_ARM;
        end
      end
      ST_ARM:    if (tDone) stateD = ST_PULSE;
      ST_PULSE:  if (tDone) stateD = ST_HOLD;
      ST_HOLD: begin
        if (tDone) begin
          if (inVerifyQ) begin
            stateD = ST_VOPEN;
          end else if (lastAddr) begin
            strb.addrClr = 1'b1;
            inVerifyD    = 1'b1;
            retryD       = '0;
            stateD       = ST_VFETCH;
          end else begin
            strb.addrInc = 1'b1;
            stateD       = ST_PFETCH;
          end
        end
      end
      ST_VFETCH: begin
        if (tDone) begin
          strb.loadExp = 1'b1;
          stateD       = ST_VOPEN;
        end
      end
      ST_VOPEN:  if (tDone) stateD = ST_VREAD;
      ST_VREAD: begin
        if (tDone) begin
          if (match) begin
            retryD = '0;
            if (lastAddr) begin
              strb.addrClr = 1'b1;
              stateD       = ST_FRAMP;
            end else begin
              strb.addrInc = 1'b1;
              stateD       = ST_VFETCH;
            end
          end else if (retryQ == RW'(MAX_RETRY)) begin
            strb.setFail = 1'b1;
            strb.finish  = 1'b1;
            stateD       = ST_IDLE;
          end else begin
            retryD = retryQ + 1'b1;
            stateD = ST_ARM;
          end
        end
      end
      ST_FRAMP:  if (tDone) stateD = ST_CFETCH;
      ST_CFETCH: begin
        if (tDone) begin
          strb.loadExp = 1'b1;
          stateD       = ST_CREAD;
        end
      end
      ST_CREAD: begin
        if (tDone) begin
          if (!match) begin
            strb.setFail = 1'b1;
            strb.finish  = 1'b1;
            stateD       = ST_IDLE;
          end else if (lastAddr) begin
            strb.setPass = 1'b1;
            strb.finish  = 1'b1;
            stateD       = ST_IDLE;
          end else begin
            strb.addrInc = 1'b1;
            stateD       = ST_CFETCH;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      timerQ    <= '0;
      retryQ    <= '0;
      inVerifyQ <= 1'b0;
    end else begin
      stateQ    <= stateD;
      retryQ    <= retryD;
      inVerifyQ <= inVerifyD;
      if (stateD != stateQ) begin
        timerQ <= durOf(stateD);
      end else if (!tDone) begin
        timerQ <= timerQ - 1'b1;
      end
    end
  end

  always_comb begin
    busy      = (stateQ != ST_IDLE);
    vppEn     = stateQ inside {ST_RAMP, ST_PFETCH, ST_ARM, ST_PULSE, ST_HOLD};
    vccHiEn   = stateQ inside {ST_RAMP, ST_PFETCH, ST_ARM, ST_PULSE, ST_HOLD,
                               ST_VFETCH, ST_VOPEN, ST_VREAD};
    memDataOe = stateQ inside {ST_ARM, ST_PULSE, ST_HOLD};
    memCeN    = !(stateQ inside {ST_PULSE, ST_VREAD, ST_CREAD});
    memOeN    = !(stateQ inside {ST_VREAD, ST_CREAD});
  end

endmodule

// File: rtl/otp_prog_dpath.sv
module otp_prog_dpath
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strb,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              lastAddr,
  output logic              match,
  output logic              done,
  output logic              passOk,
  output logic [ADDR_W-1:0] failAddr
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] expQ;
  logic              passQ, doneQ;
  logic [ADDR_W-1:0] failQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      expQ  <= '0;
      passQ <= 1'b0;
      failQ <= '0;
      doneQ <= 1'b0;
    end else begin
      if (strb.addrClr)      addrQ <= '0;
      else if (strb.addrInc) addrQ <= addrQ + 1'b1;
      if (strb.loadExp)      expQ  <= srcData;
      if (strb.clrResult) begin
        passQ <= 1'b0;
        failQ <= '0;
      end
      if (strb.setPass)      passQ <= 1'b1;
      if (strb.setFail)      failQ <= addrQ;
      doneQ <= strb.finish;
    end
  end

  assign srcAddr    = addrQ;
  assign memAddr    = addrQ;
  assign memDataOut = expQ;
  assign lastAddr   = (addrQ == {ADDR_W{1'b1}});
  assign match      = (memDataIn == expQ);
  assign done       = doneQ;
  assign passOk     = passQ;
  assign failAddr   = failQ;

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_prog_pkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter int          DATA_W    = 8,
  parameter int unsigned CLK_MHZ   = 125,
  parameter int unsigned PULSE_US  = 50,
  parameter int unsigned SETUP_US  = 2,
  parameter int unsigned HOLD_US   = 2,
  parameter int unsigned VALID_US  = 1,
  parameter int unsigned MAX_RETRY = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              passOk,
  output logic [ADDR_W-1:0] failAddr,
  output logic [ADDR_W-1:0] srcAddr,
  input  logic [DATA_W-1:0] srcData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  input  logic [DATA_W-1:0] memDataIn,
  output logic              memDataOe,
  output logic              memCeN,
  output logic              memOeN,
  output logic              vppEn,
  output logic              vccHiEn
);

  localparam int unsigned PULSE_CYC = usToCycles(CLK_MHZ, PULSE_US);
  localparam int unsigned SETUP_CYC = usToCycles(CLK_MHZ, SETUP_US);
  localparam int unsigned HOLD_CYC  = usToCycles(CLK_MHZ, HOLD_US);
  localparam int unsigned VALID_CYC = usToCycles(CLK_MHZ, VALID_US);

  seq_strobe_t strb;
  logic        lastAddr;
  logic        match;

  otp_prog_ctrl #(
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC (HOLD_CYC),
    .VALID_CYC(VALID_CYC),
    .MAX_RETRY(MAX_RETRY)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .lastAddr (lastAddr),
    .match    (match),
    .strb     (strb),
    .busy     (busy),
    .memCeN   (memCeN),
    .memOeN   (memOeN),
    .vppEn    (vppEn),
    .vccHiEn  (vccHiEn),
    .memDataOe(memDataOe)
  );

  otp_prog_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .srcData   (srcData),
    .memDataIn (memDataIn),
    .srcAddr   (srcAddr),
    .memAddr   (memAddr),
    .memDataOut(memDataOut),
    .lastAddr  (lastAddr),
    .match     (match),
    .done      (done),
    .passOk    (passOk),
    .failAddr  (failAddr)
  );

endmodule

// File: rtl/otp_prog_chk.sv
module otp_prog_chk #(
  parameter int          ADDR_W   = 20,
  parameter int          DATA_W   = 8,
  parameter int unsigned CLK_MHZ  = 125,
  parameter int unsigned PULSE_US = 50
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDataOut,
  input logic              memDataOe,
  input logic              memCeN,
  input logic              memOeN,
  input logic              vppEn,
  input logic              vccHiEn
);

  localparam int unsigned PULSE_CYC = otp_prog_pkg::usToCycles(CLK_MHZ, PULSE_US);

  logic        progPulse;
  logic [31:0] pulseRun;

  assign progPulse = !memCeN && memOeN;

  always_ff @(posedge clk) begin
    if (!rstN)          pulseRun <= '0;
    else if (progPulse) pulseRun <= pulseRun + 1'b1;
    else                pulseRun <= '0;
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(progPulse) |-> pulseRun == 32'(PULSE_CYC)); // R3
  AST_PULSE_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    progPulse |-> pulseRun < 32'(PULSE_CYC)); // R3
  AST_PULSE_SUPPLIES: assert property (@(posedge clk) disable iff (!rstN)
    progPulse |-> vppEn && vccHiEn && memDataOe); // R4
  AST_PULSE_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (progPulse && $past(progPulse)) |-> $stable(memAddr) && $stable(memDataOut)); // R4
  AST_READ_NO_VPP: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !vppEn && !memCeN); // R5
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDataOe); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> memCeN && memOeN && !vppEn && !vccHiEn && !memDataOe); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R9

endmodule

bind otp_prog_seq otp_prog_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .CLK_MHZ (CLK_MHZ),
  .PULSE_US(PULSE_US)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .done      (done),
  .memAddr   (memAddr),
  .memDataOut(memDataOut),
  .memDataOe (memDataOe),
  .memCeN    (memCeN),
  .memOeN    (memOeN),
  .vppEn     (vppEn),
  .vccHiEn   (vccHiEn)
);

// File: tb/tb_otp_prog_seq.sv
module tb_otp_prog_seq;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NW = 16;
  localparam int MHZ = 2;
  localparam int PULSE_CYC = 100;
  localparam int SETUP_CYC = 4;
  localparam int HOLD_CYC  = 4;

  typedef struct packed {
    logic       wipe;
    logic [7:0] seed;
    logic [3:0] weakAddr;
    logic [7:0] weakNeed;
    logic [3:0] decayAddr;
    logic [7:0] decayMask;
    logic       expPass;
    logic [3:0] expFailAddr;
    logic [7:0] expPulses;
    logic [7:0] expFinalReads;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'hA5, 4'd0,  8'd1,  4'd0, 8'h00, 1'b1, 4'd0, 8'd16, 8'd16}, // clean run
    '{1'b1, 8'h3C, 4'd5,  8'd4,  4'd0, 8'h00, 1'b1, 4'd0, 8'd19, 8'd16}, // three retries
    '{1'b1, 8'h3C, 4'd7,  8'd27, 4'd0, 8'h00, 1'b0, 4'd7, 8'd41, 8'd0},  // retries exhausted
    '{1'b1, 8'h3C, 4'd2,  8'd26, 4'd0, 8'h00, 1'b1, 4'd0, 8'd41, 8'd16}, // last retry succeeds
    '{1'b0, 8'h3C, 4'd0,  8'd1,  4'd0, 8'h00, 1'b1, 4'd0, 8'd16, 8'd16}, // reprogram same image
    '{1'b0, 8'hC3, 4'd0,  8'd1,  4'd0, 8'h00, 1'b0, 4'd0, 8'd41, 8'd0},  // zeros cannot go back
    '{1'b1, 8'h5A, 4'd0,  8'd1,  4'd9, 8'h10, 1'b0, 4'd9, 8'd16, 8'd10}, // final compare miss
    '{1'b1, 8'h11, 4'd15, 8'd2,  4'd0, 8'h00, 1'b1, 4'd0, 8'd17, 8'd16}  // retry at last address
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  always #4 clk = ~clk;

  logic          busy, done, passOk, memDataOe, memCeN, memOeN, vppEn, vccHiEn;
  logic [AW-1:0] failAddr, srcAddr, memAddr;
  logic [DW-1:0] srcData, memDataOut, memDataIn;

  otp_prog_seq #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(MHZ), .PULSE_US(50), .SETUP_US(2),
    .HOLD_US(2), .VALID_US(1), .MAX_RETRY(25)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .passOk(passOk), .failAddr(failAddr), .srcAddr(srcAddr), .srcData(srcData),
    .memAddr(memAddr), .memDataOut(memDataOut), .memDataIn(memDataIn),
    .memDataOe(memDataOe), .memCeN(memCeN), .memOeN(memOeN), .vppEn(vppEn),
    .vccHiEn(vccHiEn)
  );

  // source image and memory model
  logic [7:0] rom   [NW];
  logic [7:0] cells [NW];
  int         need  [NW];
  int         hits  [NW];
  logic [3:0] decayAddr;
  logic [7:0] decayMask;

  always @(posedge clk) srcData <= rom[srcAddr];

  always_comb begin
    if (!memCeN && !memOeN)
      memDataIn = cells[memAddr] ^ ((!vccHiEn && memAddr == decayAddr) ? decayMask : 8'h00);
    else
      memDataIn = 8'h00;
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  // port monitor
  int   cyc = 0, lastAddrChg = -100000, lastDataChg = -100000, vppRise = -100000;
  int   lastPulseEnd = -100000, width = 0;
  int   pulseCnt = 0, finalReads = 0, doneCycles = 0, expRetryAddr = 0;
  logic prevPulse = 1'b0, prevVpp = 1'b0, prevOeN = 1'b1;
  logic [AW-1:0] prevAddr = '0;
  logic [DW-1:0] prevData = '0;

  always @(negedge clk) begin
    if (rstN) begin
      logic pulseNow;
      cyc++;
      pulseNow = !memCeN && memOeN;
      if (memAddr != prevAddr) begin
        chk(cyc - lastPulseEnd >= HOLD_CYC, "R4 address hold after pulse", cyc - lastPulseEnd, HOLD_CYC);
        lastAddrChg = cyc;
      end
      if (memDataOut != prevData) lastDataChg = cyc;
      if (vppEn && !prevVpp) vppRise = cyc;
      if (pulseNow && !prevPulse) begin
        chk(cyc - lastAddrChg >= SETUP_CYC, "R4 address setup", cyc - lastAddrChg, SETUP_CYC);
        chk(cyc - lastDataChg >= SETUP_CYC, "R4 data setup", cyc - lastDataChg, SETUP_CYC);
        chk(cyc - vppRise >= SETUP_CYC, "R4 voltage setup", cyc - vppRise, SETUP_CYC);
        chk(memDataOe && vppEn && vccHiEn, "R4 drive and supplies in pulse",
            {memDataOe, vppEn, vccHiEn}, 7);
        if (pulseCnt < NW) chk(int'(memAddr) == pulseCnt, "R3 first-pass order", memAddr, pulseCnt);
        else chk(int'(memAddr) == expRetryAddr, "R6 retry address", memAddr, expRetryAddr);
        hits[memAddr] = hits[memAddr] + 1;
        if (hits[memAddr] >= need[memAddr]) cells[memAddr] = cells[memAddr] & memDataOut;
        pulseCnt++;
        width = 0;
      end
      if (pulseNow) width++;
      if (!pulseNow && prevPulse) begin
        chk(width == PULSE_CYC, "R3 pulse width", width, PULSE_CYC);
        lastPulseEnd = cyc;
      end
      if (!memOeN && prevOeN) begin
        chk(!memDataOe && !vppEn, "R5 R11 read with bus released and no vpp",
            {memDataOe, vppEn}, 0);
        if (!vccHiEn) finalReads++;
      end
      if (done) doneCycles++;
      prevPulse = pulseNow;
      prevVpp   = vppEn;
      prevOeN   = memOeN;
      prevAddr  = memAddr;
      prevData  = memDataOut;
    end
  end

  task automatic runOne(input vec_t v, input int idx, input bit stray);
    int n;
    for (int i = 0; i < NW; i++) begin
      rom[i]  = v.seed ^ 8'(i * 37);
      if (v.wipe) cells[i] = 8'hFF;
      need[i] = (i == int'(v.weakAddr)) ? int'(v.weakNeed) : 1;
      hits[i] = 0;
    end
    decayAddr    = v.decayAddr;
    decayMask    = v.decayMask;
    expRetryAddr = v.weakAddr;
    pulseCnt     = 0;
    finalReads   = 0;
    doneCycles   = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy && vppEn && vccHiEn && memAddr == 0 && memCeN, "R2 start raises supplies",
        {busy, vppEn, vccHiEn}, 7);
    n = 0;
    while (!done && n < 30000) begin
      @(negedge clk);
      n++;
      start = (stray && (n == 300 || n == 2000)) ? 1'b1 : 1'b0;
    end
    start = 1'b0;
    chk(done, "R9 run finished (watchdog)", idx, -1);
    chk(!busy, "R9 busy low with done", busy, 0);
    chk(!vppEn && !vccHiEn && memCeN, "R7 supplies off at end", {vppEn, vccHiEn}, 0);
    chk(passOk == v.expPass, "R7 R8 R9 result", passOk, v.expPass);
    if (!v.expPass) chk(failAddr == v.expFailAddr, "R7 R8 failing address", failAddr, v.expFailAddr);
    chk(pulseCnt == int'(v.expPulses), stray ? "R10 pulses with stray start" : "R6 total pulses",
        pulseCnt, v.expPulses);
    chk(finalReads == int'(v.expFinalReads), "R8 reads at normal supply", finalReads, v.expFinalReads);
    @(negedge clk);
    chk(doneCycles == 1, "R9 done width", doneCycles, 1);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin
      rom[i] = 8'h00;
      cells[i] = 8'hFF;
      need[i] = 1;
      hits[i] = 0;
    end
    decayAddr = '0;
    decayMask = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !passOk, "R1 idle flags in reset", {busy, done, passOk}, 0);
    chk(memCeN && memOeN, "R1 enables high in reset", {memCeN, memOeN}, 3);
    chk(!vppEn && !vccHiEn && !memDataOe, "R1 supplies and bus off in reset",
        {vppEn, vccHiEn, memDataOe}, 0);
    @(negedge clk) rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && memCeN && !vppEn, "R1 idle after reset", busy, 0);

    for (int k = 0; k < NV; k++) runOne(VECS[k], k, 1'b0);

    // R10 directed: stray start pulses mid-run are ignored
    runOne('{1'b1, 8'h77, 4'd0, 8'd1, 4'd0, 8'h00, 1'b1, 4'd0, 8'd16, 8'd16}, 100, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got %0d expected %0d", 190000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule